// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a 32 by 32 two-colour pointer on top of a scanline pixel stream. Software loads one shape word and one colour-select word per cursor row, and a packed X/Y position, through a 32-bit register port. The video pipeline feeds the block each pixel's coordinate and its base colour, which comes from the palette stage. The block returns the same stream one clock later, with the pointer painted over it. The two pointer colours arrive on input ports.

Register writes land in a working copy. A one-cycle frame pulse copies the whole working copy into a shadow copy, and only the shadow copy drives the display. The pointer therefore changes shape or position only between frames and never tears within one. A small general-purpose control register sits alongside the pointer registers. Reads of it always return bit 25 as 1.

Top module: `hwcur_overlay`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_line_start`, `out_pixel` and `reg_rdata` are 0 after that edge. Reset sets both pointer coordinates to 0xF000 (working and shadow), so an unmodified stream passes through unchanged.
- R2: Each output is the registered result of the inputs sampled one clock earlier. `out_valid` and `out_line_start` repeat `in_valid` and `in_line_start` with exactly that one-cycle delay.
- R3: Where the pointer does not cover a pixel, or the shape bit is 0, `out_pixel` equals the `in_pixel` of the previous cycle.
- R4: Where the shape bit is 1, the colour-select bit chooses the colour. A select bit of 1 gives `cur_color_b` and a select bit of 0 gives `cur_color_a`.
- R5: The pointer column is `in_x` minus pointer X, and the pointer row is `in_y` minus pointer Y. Column c uses bit 31-c of that row's words, so the leftmost column uses bit 31.
- R6: A write to byte offset 0x8FC sets pointer X from `reg_wdata[31:16]` and pointer Y from `reg_wdata[15:0]`.
- R7: A write to offset 0x900 + 4*r (r = 0..31) sets the shape word of row r. A write to 0x980 + 4*r sets the colour-select word of row r.
- R8: The pointer can cover a pixel only when pointer Y <= `in_y` < pointer Y + 32.
- R9: The pointer can cover a pixel only when pointer X < `active_width`, pointer X <= `in_x` < pointer X + 32, and `in_x` < `active_width`. This clips the pointer at the right edge.
- R10: A write to offset 0x818 stores `reg_wdata`. A read of 0x818 (`reg_rd` high) returns the stored value with bit 25 forced to 1 on `reg_rdata` one clock later. A read of any other offset, or a cycle with no read, gives 0.
- R11: The drawing logic uses only the shadow copy of position, shape and colour-select words. A `frame_sync` pulse copies into the shadow everything written before that cycle. A write in the same cycle as the pulse reaches the display only at the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |
| frame_sync | input | 1 | One-cycle pulse at vertical sync; loads shadow registers |
| active_width | input | 16 | Active pixels per line |
| cur_color_a | input | 24 | Pointer colour for select bit 0 |
| cur_color_b | input | 24 | Pointer colour for select bit 1 |
| in_valid | input | 1 | Input pixel qualifier |
| in_line_start | input | 1 | Marks first pixel of a line |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel line |
| in_pixel | input | 24 | Base colour from palette stage |
| out_valid | output | 1 | Delayed `in_valid` |
| out_line_start | output | 1 | Delayed `in_line_start` |
| out_pixel | output | 24 | Pixel after pointer overlay |

## Verification
A corrupted shadow word or position shows on `out_pixel` on the first pixel that the pointer window covers after the next frame pulse. It cannot show earlier, so the bench streams lines through that window both before and after each pulse. A wrong row or column offset, or a reversed bit order, shows as a wrong colour at a specific column within one clock of that pixel entering. The same holds for an off-by-one at the window edges, which the bench meets by streaming the lines just above and below the window and pixels past the right clip. A bad pipeline alignment appears on every cycle as a mismatch between the delayed qualifiers and the pixel.

// File: rtl/hwcur_pkg.sv
// hwcur_pkg: shared constants and types for the pointer overlay.
// Assumes a 12-bit byte-offset register space and 16-bit coordinates.
package hwcur_pkg;
    localparam int POS_W     = 16;     // width of each coordinate
    localparam int REG_W     = 32;     // register data width
    localparam int CUR_DIM   = 32;     // pointer rows and columns
    localparam int MISC_ONE  = 25;     // bit forced to 1 on misc reads

    localparam logic [11:0] OFF_MISC = 12'h818;
    localparam logic [11:0] OFF_POS  = 12'h8FC;
    localparam logic [11:0] OFF_SHP  = 12'h900;
    localparam logic [11:0] OFF_SEL  = 12'h980;

    localparam logic [POS_W-1:0] POS_PARK = 16'hF000;

    typedef struct packed {
        logic [POS_W-1:0] x;   // upper half of position word
        logic [POS_W-1:0] y;   // lower half of position word
    } cur_pos_t;
endpackage

// File: rtl/hwcur_regs.sv
// hwcur_regs: register port, working copy and frame-synchronous shadow
// copy of the pointer position, shape and colour-select words.
// Assumes DIM is a power of two and DIM == REG_W.
module hwcur_regs
    import hwcur_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DIM    = CUR_DIM
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    input  logic                     frame_sync,
    input  logic [$clog2(DIM)-1:0]   row_sel,
    output cur_pos_t                 pos_shadow,
    output logic [DIM-1:0]           shp_row,
    output logic [DIM-1:0]           sel_row
);
    localparam int ROW_W = $clog2(DIM);
    localparam int HI    = ADDR_W - 1;
    localparam int LO    = ROW_W + 2;
    localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(OFF_MISC);
    localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(OFF_POS);
    localparam logic [ADDR_W-1:0] A_SHP  = ADDR_W'(OFF_SHP);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);

    cur_pos_t          pos_work;
    logic [REG_W-1:0]  misc_q;
    logic              shp_wr, sel_wr;
    logic [ROW_W-1:0]  wr_row;
    logic [DIM-1:0]    shp_sh [DIM];
    logic [DIM-1:0]    sel_sh [DIM];

    // Decode the row-word write windows from the upper offset bits.
    assign shp_wr = wr && (addr[HI:LO] == A_SHP[HI:LO]);
    assign sel_wr = wr && (addr[HI:LO] == A_SEL[HI:LO]);
    assign wr_row = addr[LO-1:2];

    // Working and shadow position, parked off-screen at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_work   <= '{x: POS_PARK, y: POS_PARK};
            pos_shadow <= '{x: POS_PARK, y: POS_PARK};
        end else begin
            if (frame_sync) pos_shadow <= pos_work;
            if (wr && addr == A_POS) pos_work <= wdata;
        end
    end

    // Misc register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                    misc_q <= '0;
        else if (wr && addr == A_MISC) misc_q <= wdata;
    end

    // Registered read port; only the misc register reads back.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata <= '0;
        else if (rd && addr == A_MISC) rdata <= misc_q | (REG_W'(1) << MISC_ONE);
        else                           rdata <= '0;
    end

    for (genvar r = 0; r < DIM; r++) begin : g_row
        logic [DIM-1:0] shp_w, sel_w, shp_s, sel_s;

        // Per-row working words and their frame-synchronous shadows.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shp_w <= '0; sel_w <= '0; shp_s <= '0; sel_s <= '0;
            end else begin
                if (frame_sync) begin
                    shp_s <= shp_w;
                    sel_s <= sel_w;
                end
                if (shp_wr && wr_row == ROW_W'(r)) shp_w <= wdata[DIM-1:0];
                if (sel_wr && wr_row == ROW_W'(r)) sel_w <= wdata[DIM-1:0];
            end
        end
        assign shp_sh[r] = shp_s;
        assign sel_sh[r] = sel_s;
    end

    assign shp_row = shp_sh[row_sel];
    assign sel_row = sel_sh[row_sel];
endmodule

// File: rtl/hwcur_window.sv
// hwcur_window: decides whether the pointer covers the current pixel
// and yields the pointer row and column. Purely combinational.
// Assumes coordinates are unsigned and the pointer is DIM square.
module hwcur_window
    import hwcur_pkg::*;
#(
    parameter int DIM = CUR_DIM
) (
    input  cur_pos_t                 pos,
    input  logic [POS_W-1:0]         x,
    input  logic [POS_W-1:0]         y,
    input  logic [POS_W-1:0]         width,
    output logic                     hit,
    output logic [$clog2(DIM)-1:0]   row,
    output logic [$clog2(DIM)-1:0]   col
);
    localparam int ROW_W = $clog2(DIM);
    localparam logic [POS_W:0] SPAN = (POS_W+1)'(DIM);

    logic             in_rows, in_cols;
    logic [POS_W-1:0] dy, dx;

    // Window tests use one extra bit so pointer + DIM never wraps.
    always_comb begin
        in_rows = (y >= pos.y) && ({1'b0, y} < {1'b0, pos.y} + SPAN);
        in_cols = (pos.x < width) && (x >= pos.x) && (x < width)
                  && ({1'b0, x} < {1'b0, pos.x} + SPAN);
        hit     = in_rows && in_cols;
        dy      = y - pos.y;
        dx      = x - pos.x;
        row     = dy[ROW_W-1:0];
        col     = dx[ROW_W-1:0];
    end
endmodule

// File: rtl/hwcur_mux.sv
// hwcur_mux: the single pipeline stage; picks base or pointer colour
// and delays the stream qualifiers by the same one cycle.
// Assumes shape/select words are scanned from bit DIM-1 leftwards.
module hwcur_mux
    import hwcur_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int DIM   = CUR_DIM
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_line_start,
    input  logic [PIX_W-1:0]         in_pixel,
    input  logic                     hit,
    input  logic [$clog2(DIM)-1:0]   col,
    input  logic [DIM-1:0]           shp_row,
    input  logic [DIM-1:0]           sel_row,
    input  logic [PIX_W-1:0]         color_a,
    input  logic [PIX_W-1:0]         color_b,
    output logic                     out_valid,
    output logic                     out_line_start,
    output logic [PIX_W-1:0]         out_pixel
);
    localparam int ROW_W = $clog2(DIM);

    logic [ROW_W-1:0] bit_idx;
    logic [PIX_W-1:0] pix_next;

    // Leftmost column maps to the top bit of the row words.
    always_comb begin
        bit_idx  = ROW_W'(DIM - 1) - col;
        pix_next = in_pixel;
        if (hit && shp_row[bit_idx])
            pix_next = sel_row[bit_idx] ? color_b : color_a;
    end

    // Output register stage for pixel and qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_line_start <= 1'b0;
            out_pixel      <= '0;
        end else begin
            out_valid      <= in_valid;
            out_line_start <= in_line_start;
            out_pixel      <= pix_next;
        end
    end
endmodule

// File: rtl/hwcur_overlay.sv
// hwcur_overlay: top of the pointer overlay. Joins register storage,
// window test and output mux. Assumes frame_sync is a one-cycle pulse
// between frames and that colours arrive already palette-resolved.
module hwcur_overlay
    import hwcur_pkg::*;
#(
    parameter int PIX_W  = 24,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                frame_sync,
    input  logic [POS_W-1:0]    active_width,
    input  logic [PIX_W-1:0]    cur_color_a,
    input  logic [PIX_W-1:0]    cur_color_b,
    input  logic                in_valid,
    input  logic                in_line_start,
    input  logic [POS_W-1:0]    in_x,
    input  logic [POS_W-1:0]    in_y,
    input  logic [PIX_W-1:0]    in_pixel,
    output logic                out_valid,
    output logic                out_line_start,
    output logic [PIX_W-1:0]    out_pixel
);
    localparam int ROW_W = $clog2(CUR_DIM);

    cur_pos_t             shadow_pos;
    logic                 cur_hit;
    logic [ROW_W-1:0]     cur_row, cur_col;
    logic [CUR_DIM-1:0]   shp_row, sel_row;

    hwcur_regs #(.ADDR_W(ADDR_W), .DIM(CUR_DIM)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .frame_sync(frame_sync), .row_sel(cur_row),
        .pos_shadow(shadow_pos), .shp_row(shp_row), .sel_row(sel_row)
    );

    hwcur_window #(.DIM(CUR_DIM)) u_window (
        .pos(shadow_pos), .x(in_x), .y(in_y), .width(active_width),
        .hit(cur_hit), .row(cur_row), .col(cur_col)
    );

    hwcur_mux #(.PIX_W(PIX_W), .DIM(CUR_DIM)) u_mux (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_line_start(in_line_start), .in_pixel(in_pixel),
        .hit(cur_hit), .col(cur_col), .shp_row(shp_row), .sel_row(sel_row),
        .color_a(cur_color_a), .color_b(cur_color_b),
        .out_valid(out_valid), .out_line_start(out_line_start),
        .out_pixel(out_pixel)
    );
endmodule

// File: rtl/hwcur_checker.sv
// hwcur_checker: temporal properties of the pointer overlay, bound
// onto every instance of hwcur_overlay.
module hwcur_checker #(
    parameter int PIX_W  = 24,
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_line_start,
    input logic [PIX_W-1:0]    in_pixel,
    input logic                out_valid,
    input logic                out_line_start,
    input logic [PIX_W-1:0]    out_pixel,
    input logic                cur_hit,
    input logic                frame_sync,
    input logic [31:0]         shadow_pos,
    input logic                reg_rd,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_rdata
);
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    assert_start_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_line_start == $past(in_line_start));

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cur_hit)) |-> out_pixel == $past(in_pixel));

    assert_misc_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd) && $past(reg_addr) == ADDR_W'(12'h818))
        |-> reg_rdata[25]);

    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(frame_sync)) |-> $stable(shadow_pos));
endmodule

bind hwcur_overlay hwcur_checker #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_line_start(in_line_start), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_line_start(out_line_start),
    .out_pixel(out_pixel), .cur_hit(cur_hit), .frame_sync(frame_sync),
    .shadow_pos(shadow_pos), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/test_hwcur_overlay.sv
`timescale 1ns/1ps
// Bench with a behavioural reference model compared on every clock.
module test_hwcur_overlay;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0, frame_sync = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [15:0] active_width = 16'd64;
    logic [23:0] cur_color_a = 24'h0000FF, cur_color_b = 24'hFF0000;
    logic        in_valid = 0, in_line_start = 0;
    logic [15:0] in_x = 0, in_y = 0;
    logic [23:0] in_pixel = 0;
    logic        out_valid, out_line_start;
    logic [23:0] out_pixel;

    int checks = 0, fails = 0;

    // Reference model state
    logic [31:0] m_shp [32], m_sel [32], s_shp [32], s_sel [32];
    int          m_x, m_y, s_x, s_y;
    logic [31:0] m_misc;
    logic        e_valid, e_ls;
    logic [23:0] e_pix;
    logic [31:0] e_rdata;

    always #2 clk = ~clk;

    hwcur_overlay i_hwcur_overlay (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_sync(frame_sync), .active_width(active_width),
        .cur_color_a(cur_color_a), .cur_color_b(cur_color_b),
        .in_valid(in_valid), .in_line_start(in_line_start),
        .in_x(in_x), .in_y(in_y), .in_pixel(in_pixel),
        .out_valid(out_valid), .out_line_start(out_line_start),
        .out_pixel(out_pixel)
    );

    function automatic logic [23:0] ref_pixel();
        int x = int'(in_x), y = int'(in_y), w = int'(active_width);
        int row, col;
        if (y >= s_y && y < s_y + 32 && s_x < w && x >= s_x && x < s_x + 32 && x < w) begin
            row = y - s_y;
            col = x - s_x;
            if (s_shp[row][31-col]) return s_sel[row][31-col] ? cur_color_b : cur_color_a;
        end
        return in_pixel;
    endfunction

    // One clock: predict, update model, advance, compare.
    task automatic tick(string req);
        if (!rst_n) begin
            e_valid = 0; e_ls = 0; e_pix = 0; e_rdata = 0;
            m_x = 'hF000; m_y = 'hF000; s_x = 'hF000; s_y = 'hF000; m_misc = 0;
            for (int r = 0; r < 32; r++) begin
                m_shp[r] = 0; m_sel[r] = 0; s_shp[r] = 0; s_sel[r] = 0;
            end
        end else begin
            e_valid = in_valid;
            e_ls    = in_line_start;
            e_pix   = ref_pixel();
            e_rdata = (reg_rd && reg_addr == 12'h818) ? (m_misc | 32'h0200_0000) : 32'h0;
            if (frame_sync) begin
                s_x = m_x; s_y = m_y;
                for (int r = 0; r < 32; r++) begin s_shp[r] = m_shp[r]; s_sel[r] = m_sel[r]; end
            end
            if (reg_wr) begin
                if (reg_addr == 12'h8FC) begin
                    m_x = int'(reg_wdata[31:16]); m_y = int'(reg_wdata[15:0]);
                end else if (reg_addr >= 12'h900 && reg_addr < 12'h980)
                    m_shp[(reg_addr - 12'h900) >> 2] = reg_wdata;
                else if (reg_addr >= 12'h980 && reg_addr < 12'hA00)
                    m_sel[(reg_addr - 12'h980) >> 2] = reg_wdata;
                else if (reg_addr == 12'h818)
                    m_misc = reg_wdata;
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== e_valid || out_line_start !== e_ls ||
            out_pixel !== e_pix || reg_rdata !== e_rdata) begin
            fails++;
            $display("FAIL %s: got v=%b ls=%b pix=%h rd=%h, expected v=%b ls=%b pix=%h rd=%h",
                     req, out_valid, out_line_start, out_pixel, reg_rdata,
                     e_valid, e_ls, e_pix, e_rdata);
        end
    endtask

    task automatic write_reg(logic [11:0] a, logic [31:0] d, string req);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(req);
        reg_wr = 0;
    endtask

    task automatic read_reg(logic [11:0] a, string req);
        reg_rd = 1; reg_addr = a;
        tick(req);
        reg_rd = 0;
        tick(req);
    endtask

    task automatic pulse_frame(string req);
        frame_sync = 1;
        tick(req);
        frame_sync = 0;
    endtask

    // Stream one line; gap>0 drops in_valid on every gap-th pixel.
    task automatic line(int y, int x0, int x1, int gap, string req);
        for (int x = x0; x <= x1; x++) begin
            in_x = 16'(x); in_y = 16'(y);
            in_pixel = {8'(x), 8'(y), 8'h3C};
            in_valid = (gap == 0) ? 1'b1 : (x % gap != 0);
            in_line_start = (x == x0);
            tick(req);
        end
        in_valid = 0; in_line_start = 0;
        tick(req);
    endtask

    initial begin
        // R1: reset state of outputs
        repeat (3) tick("R1");
        rst_n = 1;
        // R1: parked pointer leaves stream untouched
        line(0, 0, 40, 0, "R1");
        // R7: load shape and select rows
        for (int r = 0; r < 32; r++) begin
            write_reg(12'(12'h900 + 4*r), 32'hF0F0_0FF0 ^ (32'h1 << r) ^ {r[7:0], 24'h0}, "R7");
            write_reg(12'(12'h980 + 4*r), 32'hCCCC_AAAA ^ {r[4:0], 27'h0} ^ 32'(r), "R7");
        end
        // R6: position X=10, Y=5
        write_reg(12'h8FC, {16'd10, 16'd5}, "R6");
        // R11: before the frame pulse nothing is drawn
        line(5, 0, 63, 0, "R11");
        pulse_frame("R11");
        // R8 window edges, R3/R4/R5 content
        line(4, 0, 63, 0, "R8");
        line(5, 0, 63, 0, "R3/R4/R5");
        line(20, 0, 63, 0, "R4/R5");
        line(36, 0, 63, 0, "R8");
        line(37, 0, 63, 0, "R8");
        // R2: gaps in the valid stream
        line(6, 0, 50, 3, "R2");
        // R11: write coinciding with frame pulse lands one frame later
        reg_wr = 1; reg_addr = 12'h8FC; reg_wdata = {16'd50, 16'd0};
        frame_sync = 1;
        tick("R11");
        reg_wr = 0; frame_sync = 0;
        line(5, 0, 63, 0, "R11");
        pulse_frame("R11");
        // R9: right-edge clip with X=50, width 64
        line(0, 0, 70, 0, "R9");
        line(31, 40, 70, 0, "R9");
        write_reg(12'h8FC, {16'd64, 16'd0}, "R6");
        pulse_frame("R9");
        line(0, 55, 70, 0, "R9");
        active_width = 16'd100;
        line(0, 55, 99, 0, "R9");
        // R10: misc register
        write_reg(12'h818, 32'h0000_1234, "R10");
        read_reg(12'h818, "R10");
        write_reg(12'h818, 32'hFFFF_FFFF, "R10");
        read_reg(12'h818, "R10");
        read_reg(12'h8FC, "R10");
        // R1: reset returns parked pointer
        rst_n = 0; tick("R1"); rst_n = 1;
        line(0, 55, 99, 0, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule